// File: doc/BRIEF.md
# Round-Robin Transfer Scheduler

This block orders the traffic between one shared host link and a bank of test channels. Input channels feed stimulus bits to a device under test and output channels collect its responses. The link can carry only one transfer at a time, so the scheduler decides which channel gets it next and how many bits move. It primes every input channel with a full buffer. It then serves the channels in rounds, each round started by a "levels ready" signal built from the channels' threshold flags. Within a round it empties one threshold-sized block from every output channel before it tops up every input channel by the same amount. After the loop it sends the leftover stimulus tail and collects the remaining responses.

Each transfer appears as a held request that carries a direction, a channel index and a length in bits. The link logic answers it with a one-cycle completion pulse. A start pulse captures the configuration: input and output channel counts X and Y, total vector length L, buffer depth H and threshold Q. The scheduler checks this configuration before it accepts the job.

States: IDLE (waiting for start), FILL (priming writes), CHECK (decide whether another round is needed), WAIT (waiting for levels ready), DRAIN (per-round reads), REFILL (per-round writes), TAIL (final partial writes), FLUSH (final reads), FINISH (one-cycle completion). Transitions:
- IDLE→FILL on an accepted start.
- FILL→CHECK after the last priming write.
- CHECK→WAIT when more than Q bits remain unsent.
- CHECK→TAIL when 1 to Q bits remain.
- CHECK→FLUSH when none remain.
- WAIT→DRAIN on levels ready.
- DRAIN→REFILL after the last read.
- REFILL→CHECK after the last write.
- TAIL→FLUSH after the last write.
- FLUSH→FINISH after the last read.
- FINISH→IDLE unconditionally.

Top module: `rr_xfer_sched`

## Requirements
- R1: A start is refused in any of these cases: X or Y is zero, H is below 2·Q, or L is below H. A refused start pulses `cfg_err` for one cycle on the cycle after the start edge, issues no request and leaves `busy` low. H equal to 2·Q is accepted.
- R2: After an accepted start, the first X requests are writes (`req_dir`=0) to channels 0,1,…,X-1 in turn, each of length H. The sent count then equals H.
- R3: After the priming writes, and after each round, a new round begins only while L minus the sent count exceeds Q, and only once `level_ok` is high. While it waits, no request is issued and `busy` stays high.
- R4: A round issues reads (`req_dir`=1) from channels 0…Y-1 of length Q, then writes to channels 0…X-1 of length Q. It then adds Q to the sent count and Q to the drained count.
- R5: After the last round, each input channel 0…X-1 gets a write whose length is L minus the sent count. When that length is zero, these writes are skipped entirely.
- R6: Finally each output channel 0…Y-1 gets a read whose length is L minus the drained count. This phase always takes place.
- R7: Only one request is outstanding at a time. `req_valid`, `req_dir`, `req_chan` and `req_len` hold steady until `req_done` is seen, and the next request follows only after that.
- R8: The configuration is captured at the accepted start. A start pulse while `busy` is high has no effect on the request sequence.
- R9: `done` is high for exactly one cycle, the cycle after the final read's `req_done` edge. During that cycle `busy` and `req_valid` are low.
- R10: After reset `busy`, `done`, `cfg_err` and `req_valid` are low.
- R11: A threshold setting of zero selects the default threshold of 32768 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job with the present configuration |
| cfg_in_cnt | input | CH_W | Number of input channels X |
| cfg_out_cnt | input | CH_W | Number of output channels Y |
| cfg_total | input | LEN_W | Vector length L in bits |
| cfg_depth | input | LEN_W | Channel buffer depth H in bits |
| cfg_thresh | input | LEN_W | Threshold Q in bits; zero selects the default |
| level_ok | input | 1 | Combined threshold flags: channels ready for a round |
| req_valid | output | 1 | A transfer request is presented |
| req_dir | output | 1 | 0 = host to input channel, 1 = output channel to host |
| req_chan | output | CH_W | Channel index of the request |
| req_len | output | LEN_W | Transfer length in bits |
| req_done | input | 1 | One-cycle completion of the presented request |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse when the job completes |
| cfg_err | output | 1 | One-cycle pulse when a start is refused |

## Verification
Four configurations are run against a model computed from the requirements. One ends with a remainder exactly equal to Q, so it exercises the tail path with no extra round. One has more outputs than inputs, which separates the drain index range from the refill range. One has L equal to H, which checks the skipped tail together with a flush that still happens. One runs seven rounds, which exercises the sent and drained counters over many updates. Directed runs then cover:
- refused configurations, and the exact H = 2·Q boundary;
- the default threshold;
- a held-low `level_ok`, which shows that rounds wait;
- a start pulse during a job, which must be ignored.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FILL,
        ST_CHECK,
        ST_WAIT,
        ST_DRAIN,
        ST_REFILL,
        ST_TAIL,
        ST_FLUSH,
        ST_FINISH
    } sched_state_t;

    localparam logic DIR_TO_CHAN   = 1'b0;
    localparam logic DIR_FROM_CHAN = 1'b1;

endpackage

// File: rtl/rrs_cfg_check.sv
module rrs_cfg_check #(
    parameter int CH_W       = 8,
    parameter int LEN_W      = 32,
    parameter int DEF_THRESH = 32768
) (
    input  logic [CH_W-1:0]  in_cnt,
    input  logic [CH_W-1:0]  out_cnt,
    input  logic [LEN_W-1:0] total,
    input  logic [LEN_W-1:0] depth,
    input  logic [LEN_W-1:0] thresh_raw,
    output logic [LEN_W-1:0] thresh_eff,
    output logic             cfg_ok
);
    localparam logic [LEN_W-1:0] DEF_Q = LEN_W'(DEF_THRESH);

    logic [LEN_W:0] depth_ext;
    logic [LEN_W:0] twice_q;

    always_comb begin
        thresh_eff = (thresh_raw == '0) ? DEF_Q : thresh_raw;
        depth_ext  = {1'b0, depth};
        twice_q    = {thresh_eff, 1'b0};
        cfg_ok     = (in_cnt != '0) && (out_cnt != '0) &&
                     (depth_ext >= twice_q) && (total >= depth);
    end
endmodule

// File: rtl/rrs_len_track.sv
module rrs_len_track #(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             set_fill,
    input  logic             add_round,
    input  logic [LEN_W-1:0] total,
    input  logic [LEN_W-1:0] depth,
    input  logic [LEN_W-1:0] thresh,
    output logic [LEN_W-1:0] remain,
    output logic [LEN_W-1:0] flush_len,
    output logic             more
);
    logic [LEN_W-1:0] sent_q;
    logic [LEN_W-1:0] drained_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sent_q    <= '0;
            drained_q <= '0;
        end else if (load) begin
            sent_q    <= '0;
            drained_q <= '0;
        end else if (set_fill) begin
            sent_q    <= depth;
        end else if (add_round) begin
            sent_q    <= sent_q + thresh;
            drained_q <= drained_q + thresh;
        end
    end

    always_comb begin
        remain    = total - sent_q;
        flush_len = total - drained_q;
        more      = (remain > thresh);
    end
endmodule

// File: rtl/rrs_chan_seq.sv
module rrs_chan_seq #(
    parameter int CH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic [CH_W-1:0] count,
    output logic [CH_W-1:0] idx,
    output logic            last
);
    logic [CH_W-1:0] idx_q;

    assign last = (idx_q == (count - CH_W'(1)));
    assign idx  = idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx_q <= '0;
        else if (adv)
            idx_q <= last ? '0 : idx_q + CH_W'(1);
    end
endmodule

// File: rtl/rr_xfer_sched.sv
module rr_xfer_sched
    import rrs_pkg::*;
#(
    parameter int CH_W       = 8,
    parameter int LEN_W      = 32,
    parameter int DEF_THRESH = 32768
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CH_W-1:0]  cfg_in_cnt,
    input  logic [CH_W-1:0]  cfg_out_cnt,
    input  logic [LEN_W-1:0] cfg_total,
    input  logic [LEN_W-1:0] cfg_depth,
    input  logic [LEN_W-1:0] cfg_thresh,
    input  logic             level_ok,
    output logic             req_valid,
    output logic             req_dir,
    output logic [CH_W-1:0]  req_chan,
    output logic [LEN_W-1:0] req_len,
    input  logic             req_done,
    output logic             busy,
    output logic             done,
    output logic             cfg_err
);
    sched_state_t state_q, state_d;

    logic [CH_W-1:0]  x_q, y_q;
    logic [LEN_W-1:0] tot_q, dep_q, thr_q;
    logic [LEN_W-1:0] thr_eff;
    logic             cfg_ok;
    logic [LEN_W-1:0] remain, flush_len;
    logic             more;
    logic             load, set_fill, add_round;
    logic             issuing, adv, last, phase_end;
    logic [CH_W-1:0]  idx, phase_cnt;
    logic             accept;

    rrs_cfg_check #(
        .CH_W(CH_W), .LEN_W(LEN_W), .DEF_THRESH(DEF_THRESH)
    ) cfg_i (
        .in_cnt(cfg_in_cnt), .out_cnt(cfg_out_cnt), .total(cfg_total),
        .depth(cfg_depth), .thresh_raw(cfg_thresh),
        .thresh_eff(thr_eff), .cfg_ok(cfg_ok)
    );

    rrs_len_track #(.LEN_W(LEN_W)) len_i (
        .clk(clk), .rst_n(rst_n), .load(load), .set_fill(set_fill),
        .add_round(add_round), .total(tot_q), .depth(dep_q), .thresh(thr_q),
        .remain(remain), .flush_len(flush_len), .more(more)
    );

    rrs_chan_seq #(.CH_W(CH_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .adv(adv), .count(phase_cnt),
        .idx(idx), .last(last)
    );

    assign accept    = (state_q == ST_IDLE) && start && cfg_ok;
    assign issuing   = (state_q == ST_FILL)  || (state_q == ST_DRAIN) ||
                       (state_q == ST_REFILL) || (state_q == ST_TAIL) ||
                       (state_q == ST_FLUSH);
    assign adv       = issuing && req_done;
    assign phase_end = adv && last;
    assign phase_cnt = ((state_q == ST_DRAIN) || (state_q == ST_FLUSH)) ? y_q : x_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // captured configuration and refusal pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q     <= '0;
            y_q     <= '0;
            tot_q   <= '0;
            dep_q   <= '0;
            thr_q   <= '0;
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= (state_q == ST_IDLE) && start && !cfg_ok;
            if (accept) begin
                x_q   <= cfg_in_cnt;
                y_q   <= cfg_out_cnt;
                tot_q <= cfg_total;
                dep_q <= cfg_depth;
                thr_q <= thr_eff;
            end
        end
    end

    // next state and counter control
    always_comb begin
        state_d   = state_q;
        load      = 1'b0;
        set_fill  = 1'b0;
        add_round = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_FILL;
                    load    = 1'b1;
                end
            end
            ST_FILL: begin
                if (phase_end) begin
                    state_d  = ST_CHECK;
                    set_fill = 1'b1;
                end
            end
            ST_CHECK: begin
                if (more)
                    state_d = ST_WAIT;
                else if (remain != '0)
                    state_d = ST_TAIL;
                else
                    state_d = ST_FLUSH;
            end
            ST_WAIT: begin
                if (level_ok)
                    state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (phase_end)
                    state_d = ST_REFILL;
            end
            ST_REFILL: begin
                if (phase_end) begin
                    state_d   = ST_CHECK;
                    add_round = 1'b1;
                end
            end
            ST_TAIL: begin
                if (phase_end)
                    state_d = ST_FLUSH;
            end
            ST_FLUSH: begin
                if (phase_end)
                    state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_valid = issuing;
        req_chan  = idx;
        req_dir   = DIR_TO_CHAN;
        req_len   = '0;
        busy      = (state_q != ST_IDLE) && (state_q != ST_FINISH);
        done      = (state_q == ST_FINISH);
        unique case (state_q)
            ST_FILL:   req_len = dep_q;
            ST_DRAIN: begin
                req_dir = DIR_FROM_CHAN;
                req_len = thr_q;
            end
            ST_REFILL: req_len = thr_q;
            ST_TAIL:   req_len = remain;
            ST_FLUSH: begin
                req_dir = DIR_FROM_CHAN;
                req_len = flush_len;
            end
            default: req_len = '0;
        endcase
    end
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
    parameter int CH_W  = 8,
    parameter int LEN_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             req_valid,
    input logic             req_dir,
    input logic [CH_W-1:0]  req_chan,
    input logic [LEN_W-1:0] req_len,
    input logic             req_done,
    input logic             busy,
    input logic             done,
    input logic             cfg_err
);
    assert_hold_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_done) |=> (req_valid && $stable(req_chan) &&
                                      $stable(req_len) && $stable(req_dir)));

    assert_len_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len != '0));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !req_valid));

    assert_refuse_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!busy && !req_valid));

    assert_idle_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid);

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));
endmodule

bind rr_xfer_sched rrs_checker #(.CH_W(CH_W), .LEN_W(LEN_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid),
    .req_dir(req_dir), .req_chan(req_chan), .req_len(req_len),
    .req_done(req_done), .busy(busy), .done(done), .cfg_err(cfg_err)
);

// File: tb/rr_xfer_sched_tb_top.sv
`timescale 1ns/1ps
module rr_xfer_sched_tb_top;
    localparam int CH_W  = 8;
    localparam int LEN_W = 32;
    localparam int MAXR  = 256;

    localparam int NV = 4;
    localparam int TV_X[NV]    = '{2, 1, 2, 3};
    localparam int TV_Y[NV]    = '{1, 2, 2, 1};
    localparam int TV_L[NV]    = '{40, 32, 16, 100};
    localparam int TV_H[NV]    = '{16, 16, 16, 20};
    localparam int TV_Q[NV]    = '{8, 8, 8, 10};
    localparam int TV_NREQ[NV] = '{11, 7, 4, 35};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CH_W-1:0]  cfg_in_cnt = '0, cfg_out_cnt = '0;
    logic [LEN_W-1:0] cfg_total = '0, cfg_depth = '0, cfg_thresh = '0;
    logic             level_ok = 1'b0;
    logic             req_valid, req_dir;
    logic [CH_W-1:0]  req_chan;
    logic [LEN_W-1:0] req_len;
    logic             req_done = 1'b0;
    logic             busy, done, cfg_err;

    int checks = 0, fails = 0;
    int cyc = 0, done_cnt = 0, done_cyc = -1, last_rd_cyc = -5, err_cnt = 0;
    bit auto_level = 1'b1;
    int idle_run = 0;

    int obs_n = 0;
    int obs_dir[MAXR], obs_chan[MAXR], obs_len[MAXR];
    int exp_n = 0;
    int exp_dir[MAXR], exp_chan[MAXR], exp_len[MAXR];
    string exp_tag[MAXR];

    always #10 clk = ~clk;

    rr_xfer_sched #(.CH_W(CH_W), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_in_cnt(cfg_in_cnt),
        .cfg_out_cnt(cfg_out_cnt), .cfg_total(cfg_total), .cfg_depth(cfg_depth),
        .cfg_thresh(cfg_thresh), .level_ok(level_ok), .req_valid(req_valid),
        .req_dir(req_dir), .req_chan(req_chan), .req_len(req_len),
        .req_done(req_done), .busy(busy), .done(done), .cfg_err(cfg_err)
    );

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // link responder: records each request and completes it after a delay
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && req_valid) begin
                if (obs_n < MAXR) begin
                    obs_dir[obs_n]  = int'(req_dir);
                    obs_chan[obs_n] = int'(req_chan);
                    obs_len[obs_n]  = int'(req_len);
                end
                obs_n++;
                repeat (2) @(negedge clk);
                req_done = 1'b1;
                @(negedge clk);
                req_done = 1'b0;
            end
        end
    end

    // monitor and level driver, just after each falling edge
    always @(negedge clk) begin
        #1;
        cyc++;
        if (done) begin done_cnt++; done_cyc = cyc; end
        if (req_done) last_rd_cyc = cyc;
        if (cfg_err) err_cnt++;
        if (level_ok) level_ok = 1'b0;
        else if (auto_level && busy && !req_valid) begin
            idle_run++;
            if (idle_run >= 4) begin level_ok = 1'b1; idle_run = 0; end
        end else idle_run = 0;
    end

    task automatic add_exp(int d, int c, int l, string t);
        exp_dir[exp_n] = d; exp_chan[exp_n] = c; exp_len[exp_n] = l;
        exp_tag[exp_n] = t; exp_n++;
    endtask

    task automatic build_exp(int x, int y, int l, int h, int q_raw);
        int q, p, d;
        q = (q_raw == 0) ? 32768 : q_raw;
        exp_n = 0;
        for (int i = 0; i < x; i++) add_exp(0, i, h, "R2");
        p = h; d = 0;
        while (l - p > q) begin
            for (int j = 0; j < y; j++) add_exp(1, j, q, "R4");
            for (int i = 0; i < x; i++) add_exp(0, i, q, "R4");
            p += q; d += q;
        end
        if (l - p != 0)
            for (int i = 0; i < x; i++) add_exp(0, i, l - p, "R5");
        for (int j = 0; j < y; j++) add_exp(1, j, l - d, "R6");
    endtask

    task automatic set_cfg(int x, int y, int l, int h, int q);
        cfg_in_cnt = CH_W'(x); cfg_out_cnt = CH_W'(y);
        cfg_total = LEN_W'(l); cfg_depth = LEN_W'(h); cfg_thresh = LEN_W'(q);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(int dc0);
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (done_cnt != dc0) break;
        end
        @(negedge clk); #2;
    endtask

    task automatic compare_run(int dc0, string name);
        check(obs_n == exp_n, "R7", {name, " request count"}, obs_n, exp_n);
        for (int k = 0; k < exp_n && k < obs_n; k++) begin
            check(obs_dir[k] == exp_dir[k], exp_tag[k], {name, " dir"}, obs_dir[k], exp_dir[k]);
            check(obs_chan[k] == exp_chan[k], exp_tag[k], {name, " chan"}, obs_chan[k], exp_chan[k]);
            check(obs_len[k] == exp_len[k], exp_tag[k], {name, " len"}, obs_len[k], exp_len[k]);
        end
        check(done_cnt == dc0 + 1, "R9", {name, " done pulses"}, done_cnt - dc0, 1);
        check(done_cyc == last_rd_cyc + 1, "R9", {name, " done timing"}, done_cyc, last_rd_cyc + 1);
        check(busy == 1'b0, "R9", {name, " busy after done"}, int'(busy), 0);
    endtask

    task automatic run_case(int x, int y, int l, int h, int q, bit poke, string name);
        int dc0;
        build_exp(x, y, l, h, q);
        obs_n = 0; dc0 = done_cnt;
        set_cfg(x, y, l, h, q);
        pulse_start();
        if (poke) begin
            repeat (10) @(negedge clk);
            set_cfg(1, 1, 500, 300, 100);
            start = 1'b1; @(negedge clk); start = 1'b0;
        end
        wait_done(dc0);
        compare_run(dc0, name);
    endtask

    task automatic refuse_case(int x, int y, int l, int h, int q, string name);
        int e0;
        e0 = err_cnt; obs_n = 0;
        set_cfg(x, y, l, h, q);
        pulse_start();
        repeat (3) @(negedge clk); #2;
        check(err_cnt == e0 + 1, "R1", {name, " cfg_err pulses"}, err_cnt - e0, 1);
        check(obs_n == 0, "R1", {name, " requests"}, obs_n, 0);
        check(busy == 1'b0, "R1", {name, " busy"}, int'(busy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        check(busy == 1'b0 && done == 1'b0 && cfg_err == 1'b0 && req_valid == 1'b0,
              "R10", "outputs in reset", int'({busy, done, cfg_err, req_valid}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk); #2;
        check(busy == 1'b0 && req_valid == 1'b0, "R10", "idle after reset",
              int'({busy, req_valid}), 0);

        for (int v = 0; v < NV; v++) begin
            build_exp(TV_X[v], TV_Y[v], TV_L[v], TV_H[v], TV_Q[v]);
            check(exp_n == TV_NREQ[v], "R4", "table request total", exp_n, TV_NREQ[v]);
            run_case(TV_X[v], TV_Y[v], TV_L[v], TV_H[v], TV_Q[v], 1'b0, "vector");
        end

        // R1 refusals
        refuse_case(1, 1, 40, 15, 8, "depth below twice threshold");
        refuse_case(1, 1, 10, 16, 8, "length below depth");
        refuse_case(0, 1, 40, 16, 8, "zero inputs");
        refuse_case(2, 0, 40, 16, 8, "zero outputs");
        // R1 boundary: depth exactly twice threshold is accepted
        run_case(1, 1, 30, 16, 8, 1'b0, "R1 boundary");

        // R11 default threshold
        run_case(1, 1, 98404, 65536, 0, 1'b0, "R11 default");

        // R8 start during a job is ignored
        run_case(2, 2, 60, 20, 10, 1'b1, "R8 busy start");

        // R3 rounds wait for level_ok
        begin
            int dc0;
            auto_level = 1'b0;
            build_exp(1, 1, 32, 16, 4);
            obs_n = 0; dc0 = done_cnt;
            set_cfg(1, 1, 32, 16, 4);
            pulse_start();
            repeat (60) @(negedge clk); #2;
            check(obs_n == 1, "R3", "requests while level low", obs_n, 1);
            check(busy == 1'b1, "R3", "busy while waiting", int'(busy), 1);
            auto_level = 1'b1;
            wait_done(dc0);
            compare_run(dc0, "R3 held level");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule